// File: doc/BRIEF.md
# Mode Register Command Timing Guard

This block sits on the command path between a DDR3-style controller's scheduler and the memory command bus. The scheduler offers one request per cycle: a command class (NOP, deselect, mode register write, or any other command), the target mode register, and the full address word that carries the register contents. The guard checks the request against the bank state, the burst state and the waits that follow every mode register write. It then either forwards the request to the bus one cycle later or rejects it. A rejected request leaves the bus idle and is reported with a violation code.

Four down-counters track the windows that a granted mode register write opens:
- the spacing to the next mode register write;
- the spacing to the next ordinary command, stretched when the write changes CAS latency;
- the period during which the clock enable must stay high;
- the settling time before the new settings may be used. This time is stretched when the write is a DLL reset.

A small state machine (ST_BOOT, ST_SETTLE, ST_READY) drives `features_valid`. The transitions are:
- ST_BOOT to ST_SETTLE on the first granted write;
- ST_SETTLE to ST_SETTLE on any further granted write;
- ST_SETTLE to ST_READY when the settling counter is empty and no write is granted;
- ST_READY to ST_SETTLE on any granted write.

The wait lengths are static configuration inputs counted in clock cycles.

Top module: `mrs_cmd_guard`

## Requirements
- R1: A mode register write (command 2'b10) is granted only when `banks_idle` and `trp_done` are high and `burst_active` is low. Otherwise it is rejected with code 1 (banks not idle or precharge time not met). If banks are idle and precharge is met but a burst is active, it is rejected with code 2. Code 1 takes priority over code 2.
- R2: A mode register write requested fewer than `cfg_tmrd` cycles after a granted one is rejected with code 3. A write requested exactly `cfg_tmrd` cycles later is granted.
- R3: An other command (2'b11) requested fewer than `cfg_tmod` cycles after a granted write is rejected with code 4. It is granted from `cfg_tmod` cycles on, and it is granted freely if no write has been granted since reset.
- R4: When the granted write has `req_cl_change` high, the other-command window becomes the larger of `cfg_tmod` and `cfg_txpdll`.
- R5: NOP (2'b00) and deselect (2'b01) are always forwarded. A write after `cfg_tmrd` cycles is granted even while the other-command window is still open.
- R6: `cke_out` is `cke_req` forced high during the request cycle of a granted write and the following `cfg_tmrspden`-1 request cycles. If `cke_req` is low in that span and no command rule is broken, code 5 is raised and the command itself is still forwarded.
- R7: `features_valid` is low from reset and low in the cycle a granted write appears on the bus. It rises W cycles after that bus cycle. W is `cfg_tmod`, widened to at least `cfg_txpdll` when `req_cl_change` is high, and to at least `cfg_tdll` for a DLL reset. A DLL reset is a write to register 0 (`req_mr_sel` = 0) with `req_addr[8]` set. Bit 8 in any other register has no effect on W.
- R8: A later granted write never shortens a wait that is still running. Each counter keeps the larger of its remaining count and the new length.
- R9: A rejected request gives `bus_valid` low, `bus_cmd` = deselect, and `violation` high with `viol_code` set for that one cycle. The codes are 1 to 5 as above, with 0 meaning none.
- R10: A granted request appears on the bus one cycle after its request cycle with its command, `req_mr_sel` and the full `req_addr` unchanged. There is no merging with earlier contents.
- R11: An active-low asynchronous reset clears all windows and outputs. After reset, `bus_cmd` is deselect and `cke_out`, `violation` and `features_valid` are low. A write requested right after release is granted.
- R12: With `req_valid` low, nothing is forwarded and no command violation is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_tmrd | input | CNT_W | Write-to-write spacing in cycles |
| cfg_tmod | input | CNT_W | Write-to-other-command spacing in cycles |
| cfg_tmrspden | input | CNT_W | Clock-enable hold after a write, in cycles |
| cfg_txpdll | input | CNT_W | Extra spacing after a CAS latency change |
| cfg_tdll | input | CNT_W | Settling time after a DLL reset |
| req_valid | input | 1 | Request present |
| req_cmd | input | 2 | 00 NOP, 01 deselect, 10 mode write, 11 other |
| req_mr_sel | input | BANK_W | Target mode register |
| req_addr | input | ADDR_W | Full register contents / address |
| req_cl_change | input | 1 | Write changes CAS latency |
| banks_idle | input | 1 | All banks idle |
| trp_done | input | 1 | Precharge time elapsed |
| burst_active | input | 1 | Data burst in progress |
| cke_req | input | 1 | Requested clock enable |
| bus_valid | output | 1 | Forwarded command valid |
| bus_cmd | output | 2 | Forwarded command class |
| bus_mr_sel | output | BANK_W | Forwarded register select |
| bus_addr | output | ADDR_W | Forwarded address word |
| cke_out | output | 1 | Clock enable to the bus |
| violation | output | 1 | Rule broken this cycle |
| viol_code | output | 3 | Which rule was broken |
| features_valid | output | 1 | New mode settings usable |

## Verification
Some faults in the windows show at the ports within one request. A counter that is wrong, or a state machine stuck in the wrong state, lets a request through early or rejects one late. That is visible as a wrong `bus_valid` or `viol_code` in the cycle after the request at the window edge. A bad reload rule only shows when a second write lands inside a longer pending wait. `features_valid` then rises early, several cycles after that second write. A CKE hold fault shows as `cke_out` low in the cycle after a dropped `cke_req` inside the hold span.

// File: rtl/mrs_guard_pkg.sv
package mrs_guard_pkg;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'b00,
        CMD_DES   = 2'b01,
        CMD_MRS   = 2'b10,
        CMD_OTHER = 2'b11
    } cmd_e;

    typedef enum logic [2:0] {
        VIO_NONE     = 3'd0,
        VIO_NOT_IDLE = 3'd1,
        VIO_BURST    = 3'd2,
        VIO_MRD      = 3'd3,
        VIO_MOD      = 3'd4,
        VIO_CKE      = 3'd5
    } vio_e;

    typedef enum logic [1:0] {
        ST_BOOT   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_READY  = 2'd2
    } settle_e;

    localparam int WIN_MRD  = 0;
    localparam int WIN_MOD  = 1;
    localparam int WIN_CKE  = 2;
    localparam int WIN_FEAT = 3;
    localparam int NUM_WIN  = 4;

    localparam int DLL_RESET_BIT = 8;

endpackage

// File: rtl/mrs_wait_cnt.sv
module mrs_wait_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             busy
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] dec;
    logic [CNT_W-1:0] len_m1;
    logic [CNT_W-1:0] nxt;

    always_comb begin
        dec    = (cnt == '0) ? '0 : cnt - ONE;
        len_m1 = (len == '0) ? '0 : len - ONE;
        if (load) begin
            // never shorten a wait that is still running
            nxt = (dec > len_m1) ? dec : len_m1;
        end else begin
            nxt = dec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            cnt <= nxt;
        end
    end

    assign busy = (cnt != '0);

endmodule

// File: rtl/mrs_rule_check.sv
module mrs_rule_check
    import mrs_guard_pkg::*;
(
    input  logic       req_valid,
    input  logic [1:0] req_cmd,
    input  logic       banks_idle,
    input  logic       trp_done,
    input  logic       burst_active,
    input  logic       cke_req,
    input  logic       mrd_busy,
    input  logic       mod_busy,
    input  logic       cke_busy,
    output logic       fwd,
    output logic       mrs_go,
    output logic       cke_hold,
    output vio_e       vio
);
    cmd_e cmd;
    vio_e cmd_vio;

    assign cmd = cmd_e'(req_cmd);

    always_comb begin
        cmd_vio = VIO_NONE;
        fwd     = 1'b0;
        mrs_go  = 1'b0;
        if (req_valid) begin
            unique case (cmd)
                CMD_MRS: begin
                    if (!(banks_idle && trp_done)) begin
                        cmd_vio = VIO_NOT_IDLE;
                    end else if (burst_active) begin
                        cmd_vio = VIO_BURST;
                    end else if (mrd_busy) begin
                        cmd_vio = VIO_MRD;
                    end else begin
                        fwd    = 1'b1;
                        mrs_go = 1'b1;
                    end
                end
                CMD_OTHER: begin
                    if (mod_busy) begin
                        cmd_vio = VIO_MOD;
                    end else begin
                        fwd = 1'b1;
                    end
                end
                CMD_NOP, CMD_DES: begin
                    fwd = 1'b1;
                end
            endcase
        end
    end

    always_comb begin
        cke_hold = cke_busy || mrs_go;
        if (cmd_vio != VIO_NONE) begin
            vio = cmd_vio;
        end else if (cke_hold && !cke_req) begin
            vio = VIO_CKE;
        end else begin
            vio = VIO_NONE;
        end
    end

endmodule

// File: rtl/mrs_settle_fsm.sv
module mrs_settle_fsm
    import mrs_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mrs_go,
    input  logic wait_busy,
    output logic features_valid
);
    settle_e state;
    settle_e state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_BOOT;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_BOOT: begin
                if (mrs_go) state_nxt = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (mrs_go)          state_nxt = ST_SETTLE;
                else if (!wait_busy) state_nxt = ST_READY;
            end
            ST_READY: begin
                if (mrs_go) state_nxt = ST_SETTLE;
            end
            default: state_nxt = ST_BOOT;
        endcase
    end

    always_comb begin
        unique case (state)
            ST_READY: features_valid = 1'b1;
            default:  features_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/mrs_cmd_guard.sv
module mrs_cmd_guard
    import mrs_guard_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 13,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cfg_tmrd,
    input  logic [CNT_W-1:0]  cfg_tmod,
    input  logic [CNT_W-1:0]  cfg_tmrspden,
    input  logic [CNT_W-1:0]  cfg_txpdll,
    input  logic [CNT_W-1:0]  cfg_tdll,
    input  logic              req_valid,
    input  logic [1:0]        req_cmd,
    input  logic [BANK_W-1:0] req_mr_sel,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_cl_change,
    input  logic              banks_idle,
    input  logic              trp_done,
    input  logic              burst_active,
    input  logic              cke_req,
    output logic              bus_valid,
    output logic [1:0]        bus_cmd,
    output logic [BANK_W-1:0] bus_mr_sel,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              cke_out,
    output logic              violation,
    output logic [2:0]        viol_code,
    output logic              features_valid
);

    function automatic logic [CNT_W-1:0] wmax(input logic [CNT_W-1:0] a,
                                              input logic [CNT_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

    logic [CNT_W-1:0]   win_len [NUM_WIN];
    logic [NUM_WIN-1:0] win_busy;
    logic               is_dll_reset;
    logic               fwd;
    logic               mrs_go;
    logic               cke_hold;
    vio_e               vio;

    assign is_dll_reset = (req_mr_sel == '0) && req_addr[DLL_RESET_BIT];

    always_comb begin
        win_len[WIN_MRD]  = cfg_tmrd;
        win_len[WIN_MOD]  = req_cl_change ? wmax(cfg_tmod, cfg_txpdll) : cfg_tmod;
        win_len[WIN_CKE]  = cfg_tmrspden;
        win_len[WIN_FEAT] = is_dll_reset ? wmax(win_len[WIN_MOD], cfg_tdll)
                                         : win_len[WIN_MOD];
    end

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        mrs_wait_cnt #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (mrs_go),
            .len   (win_len[w]),
            .busy  (win_busy[w])
        );
    end

    mrs_rule_check u_rules (
        .req_valid    (req_valid),
        .req_cmd      (req_cmd),
        .banks_idle   (banks_idle),
        .trp_done     (trp_done),
        .burst_active (burst_active),
        .cke_req      (cke_req),
        .mrd_busy     (win_busy[WIN_MRD]),
        .mod_busy     (win_busy[WIN_MOD]),
        .cke_busy     (win_busy[WIN_CKE]),
        .fwd          (fwd),
        .mrs_go       (mrs_go),
        .cke_hold     (cke_hold),
        .vio          (vio)
    );

    mrs_settle_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .mrs_go         (mrs_go),
        .wait_busy      (win_busy[WIN_FEAT]),
        .features_valid (features_valid)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_valid  <= 1'b0;
            bus_cmd    <= CMD_DES;
            bus_mr_sel <= '0;
            bus_addr   <= '0;
            cke_out    <= 1'b0;
            violation  <= 1'b0;
            viol_code  <= VIO_NONE;
        end else begin
            bus_valid  <= fwd;
            bus_cmd    <= fwd ? req_cmd : CMD_DES;
            bus_mr_sel <= fwd ? req_mr_sel : '0;
            bus_addr   <= fwd ? req_addr : '0;
            cke_out    <= cke_req || cke_hold;
            violation  <= (vio != VIO_NONE);
            viol_code  <= vio;
        end
    end

endmodule

// File: rtl/mrs_cmd_guard_chk.sv
module mrs_cmd_guard_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cfg_tmrd,
    input logic [CNT_W-1:0] cfg_tmod,
    input logic [CNT_W-1:0] cfg_tmrspden,
    input logic             banks_idle,
    input logic             trp_done,
    input logic             burst_active,
    input logic             bus_valid,
    input logic [1:0]       bus_cmd,
    input logic             cke_out,
    input logic             violation,
    input logic [2:0]       viol_code,
    input logic             features_valid
);
    localparam logic [CNT_W:0] GAP_MAX = '1;

    logic           seen;
    logic [CNT_W:0] gap;
    logic           bus_mrs;
    logic           bus_oth;

    assign bus_mrs = bus_valid && (bus_cmd == 2'b10);
    assign bus_oth = bus_valid && (bus_cmd == 2'b11);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen <= 1'b0;
            gap  <= '0;
        end else if (bus_mrs) begin
            seen <= 1'b1;
            gap  <= (CNT_W+1)'(1);
        end else if (gap != GAP_MAX) begin
            gap  <= gap + (CNT_W+1)'(1);
        end
    end

    assert_mrs_precond_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_mrs |-> $past(banks_idle && trp_done && !burst_active));

    assert_mrs_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_mrs && seen) |-> (gap >= {1'b0, cfg_tmrd}));

    assert_other_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oth && seen) |-> (gap >= {1'b0, cfg_tmod}));

    assert_cke_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_mrs || (seen && gap < {1'b0, cfg_tmrspden})) |-> cke_out);

    assert_features_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_mrs |-> !features_valid);

    assert_reject_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (violation && viol_code != 3'd5) |-> (!bus_valid && bus_cmd == 2'b01));

endmodule

bind mrs_cmd_guard mrs_cmd_guard_chk #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_tmrd       (cfg_tmrd),
    .cfg_tmod       (cfg_tmod),
    .cfg_tmrspden   (cfg_tmrspden),
    .banks_idle     (banks_idle),
    .trp_done       (trp_done),
    .burst_active   (burst_active),
    .bus_valid      (bus_valid),
    .bus_cmd        (bus_cmd),
    .cke_out        (cke_out),
    .violation      (violation),
    .viol_code      (viol_code),
    .features_valid (features_valid)
);

// File: tb/sim_mrs_cmd_guard.sv
module sim_mrs_cmd_guard;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W  = 8;
    localparam int ADDR_W = 13;
    localparam int BANK_W = 2;

    localparam logic [1:0] C_NOP = 2'b00;
    localparam logic [1:0] C_DES = 2'b01;
    localparam logic [1:0] C_MRS = 2'b10;
    localparam logic [1:0] C_OTH = 2'b11;
    localparam logic [ADDR_W-1:0] ADDR_PAT = 13'h0120;

    // {id[4], valid, cmd[2], idle trp burst cke cl dll, gnt, code[3], cke_out, fv}
    localparam int NV = 31;
    localparam logic [18:0] VEC [NV] = '{
        {4'd5,  1'b1, C_NOP, 6'b110100, 1'b1, 3'd0, 1'b1, 1'b0}, // R5
        {4'd3,  1'b1, C_OTH, 6'b110100, 1'b1, 3'd0, 1'b1, 1'b0}, // R3 no write yet
        {4'd1,  1'b1, C_MRS, 6'b010100, 1'b0, 3'd1, 1'b1, 1'b0}, // R1 banks busy
        {4'd1,  1'b1, C_MRS, 6'b100100, 1'b0, 3'd1, 1'b1, 1'b0}, // R1 trp not met
        {4'd1,  1'b1, C_MRS, 6'b111100, 1'b0, 3'd2, 1'b1, 1'b0}, // R1 burst
        {4'd10, 1'b1, C_MRS, 6'b110100, 1'b1, 3'd0, 1'b1, 1'b0}, // R10 write reg 2
        {4'd2,  1'b1, C_MRS, 6'b110100, 1'b0, 3'd3, 1'b1, 1'b0}, // R2 too soon
        {4'd6,  1'b1, C_NOP, 6'b110000, 1'b1, 3'd5, 1'b1, 1'b0}, // R6 cke drop
        {4'd3,  1'b1, C_OTH, 6'b110100, 1'b0, 3'd4, 1'b1, 1'b0}, // R3 too soon
        {4'd3,  1'b1, C_OTH, 6'b110100, 1'b1, 3'd0, 1'b1, 1'b1}, // R3 edge, R7 rise
        {4'd6,  1'b1, C_NOP, 6'b110000, 1'b1, 3'd0, 1'b0, 1'b1}, // R6 free drop
        {4'd4,  1'b1, C_MRS, 6'b110110, 1'b1, 3'd0, 1'b1, 1'b0}, // R4 CL change
        {4'd4,  1'b1, C_OTH, 6'b110100, 1'b0, 3'd4, 1'b1, 1'b0}, // R4
        {4'd5,  1'b1, C_DES, 6'b110100, 1'b1, 3'd0, 1'b1, 1'b0}, // R5
        {4'd5,  1'b1, C_NOP, 6'b110100, 1'b1, 3'd0, 1'b1, 1'b0}, // R5
        {4'd5,  1'b1, C_NOP, 6'b110100, 1'b1, 3'd0, 1'b1, 1'b0}, // R5
        {4'd4,  1'b1, C_OTH, 6'b110100, 1'b0, 3'd4, 1'b1, 1'b0}, // R4 past tMOD
        {4'd4,  1'b1, C_OTH, 6'b110100, 1'b1, 3'd0, 1'b1, 1'b1}, // R4 edge
        {4'd7,  1'b1, C_MRS, 6'b110101, 1'b1, 3'd0, 1'b1, 1'b0}, // R7 DLL reset
        {4'd2,  1'b1, C_MRS, 6'b110100, 1'b0, 3'd3, 1'b1, 1'b0}, // R2
        {4'd8,  1'b1, C_MRS, 6'b110100, 1'b1, 3'd0, 1'b1, 1'b0}, // R8 and R5
        {4'd8,  1'b1, C_NOP, 6'b110100, 1'b1, 3'd0, 1'b1, 1'b0}, // R8
        {4'd8,  1'b1, C_NOP, 6'b110100, 1'b1, 3'd0, 1'b1, 1'b0}, // R8
        {4'd8,  1'b1, C_NOP, 6'b110100, 1'b1, 3'd0, 1'b1, 1'b0}, // R8
        {4'd8,  1'b1, C_NOP, 6'b110100, 1'b1, 3'd0, 1'b1, 1'b0}, // R8
        {4'd8,  1'b1, C_NOP, 6'b110100, 1'b1, 3'd0, 1'b1, 1'b0}, // R8
        {4'd7,  1'b1, C_NOP, 6'b110100, 1'b1, 3'd0, 1'b1, 1'b1}, // R7 DLL wait over
        {4'd12, 1'b0, C_OTH, 6'b110100, 1'b0, 3'd0, 1'b1, 1'b1}, // R12
        {4'd5,  1'b1, C_DES, 6'b110100, 1'b1, 3'd0, 1'b1, 1'b1}, // R5
        {4'd1,  1'b1, C_MRS, 6'b011100, 1'b0, 3'd1, 1'b1, 1'b1}, // R1 priority
        {4'd10, 1'b1, C_MRS, 6'b110100, 1'b1, 3'd0, 1'b1, 1'b0}  // R10
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [CNT_W-1:0]  cfg_tmrd = 8'd2, cfg_tmod = 8'd4, cfg_tmrspden = 8'd3;
    logic [CNT_W-1:0]  cfg_txpdll = 8'd6, cfg_tdll = 8'd8;
    logic              req_valid = 1'b0;
    logic [1:0]        req_cmd = C_NOP;
    logic [BANK_W-1:0] req_mr_sel = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_cl_change = 1'b0;
    logic              banks_idle = 1'b1, trp_done = 1'b1, burst_active = 1'b0;
    logic              cke_req = 1'b1;
    logic              bus_valid, cke_out, violation, features_valid;
    logic [1:0]        bus_cmd;
    logic [BANK_W-1:0] bus_mr_sel;
    logic [ADDR_W-1:0] bus_addr;
    logic [2:0]        viol_code;

    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mrs_cmd_guard #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .BANK_W(BANK_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_tmrd(cfg_tmrd), .cfg_tmod(cfg_tmod), .cfg_tmrspden(cfg_tmrspden),
        .cfg_txpdll(cfg_txpdll), .cfg_tdll(cfg_tdll),
        .req_valid(req_valid), .req_cmd(req_cmd), .req_mr_sel(req_mr_sel),
        .req_addr(req_addr), .req_cl_change(req_cl_change),
        .banks_idle(banks_idle), .trp_done(trp_done), .burst_active(burst_active),
        .cke_req(cke_req),
        .bus_valid(bus_valid), .bus_cmd(bus_cmd), .bus_mr_sel(bus_mr_sel),
        .bus_addr(bus_addr), .cke_out(cke_out), .violation(violation),
        .viol_code(viol_code), .features_valid(features_valid)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [1:0] c, input logic [5:0] f);
        req_valid     = v;
        req_cmd       = c;
        banks_idle    = f[5];
        trp_done      = f[4];
        burst_active  = f[3];
        cke_req       = f[2];
        req_cl_change = f[1];
        req_mr_sel    = f[0] ? 2'd0 : 2'd2;
        req_addr      = ADDR_PAT;
    endtask

    task automatic expect_out(input string tag, input logic g, input logic [2:0] code,
                              input logic k, input logic fv);
        chk(tag, "bus_valid", 32'(bus_valid), 32'(g));
        chk(tag, "viol_code", 32'(viol_code), 32'(code));
        chk(tag, "violation", 32'(violation), 32'(code != 3'd0));
        chk(tag, "cke_out", 32'(cke_out), 32'(k));
        chk(tag, "features_valid", 32'(features_valid), 32'(fv));
    endtask

    initial begin
        // R11: state during reset
        repeat (3) @(negedge clk);
        expect_out("R11", 1'b0, 3'd0, 1'b0, 1'b0);
        chk("R11", "bus_cmd", 32'(bus_cmd), 32'(C_DES));
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [18:0] v;
            string tag;
            v = VEC[i];
            tag = $sformatf("R%0d", v[18:15]);
            drive(v[14], v[13:12], v[11:6]);
            @(negedge clk);
            expect_out(tag, v[5], v[4:2], v[1], v[0]);
            if (v[5]) begin
                // R10: forwarded unchanged
                chk(tag, "bus_cmd", 32'(bus_cmd), 32'(v[13:12]));
                if (v[13:12] == C_MRS) begin
                    chk("R10", "bus_addr", 32'(bus_addr), 32'(ADDR_PAT));
                    chk("R10", "bus_mr_sel", 32'(bus_mr_sel), v[6] ? 32'd0 : 32'd2);
                end
            end else begin
                chk(tag, "bus_cmd idle", 32'(bus_cmd), 32'(C_DES)); // R9
            end
        end

        // R11: reset while the write spacing window is open
        rst_n = 1'b0;
        drive(1'b0, C_NOP, 6'b110100);
        @(negedge clk);
        expect_out("R11", 1'b0, 3'd0, 1'b0, 1'b0);
        chk("R11", "bus_cmd", 32'(bus_cmd), 32'(C_DES));
        rst_n = 1'b1;
        drive(1'b1, C_MRS, 6'b110100);
        @(negedge clk);
        expect_out("R11", 1'b1, 3'd0, 1'b1, 1'b0);
        @(negedge clk);
        expect_out("R2", 1'b0, 3'd3, 1'b1, 1'b0);

        // shortest windows: all lengths of one cycle
        drive(1'b1, C_NOP, 6'b110100);
        cfg_tmrd = 8'd1; cfg_tmod = 8'd1; cfg_tmrspden = 8'd1;
        cfg_txpdll = 8'd1; cfg_tdll = 8'd1;
        repeat (10) @(negedge clk);
        drive(1'b1, C_MRS, 6'b110100);
        @(negedge clk);
        expect_out("R2", 1'b1, 3'd0, 1'b1, 1'b0);
        @(negedge clk);
        expect_out("R2", 1'b1, 3'd0, 1'b1, 1'b0);
        drive(1'b1, C_OTH, 6'b110100);
        @(negedge clk);
        expect_out("R3", 1'b1, 3'd0, 1'b1, 1'b1);
        drive(1'b1, C_NOP, 6'b110000);
        @(negedge clk);
        expect_out("R6", 1'b1, 3'd0, 1'b0, 1'b1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

endmodule